// File: doc/BRIEF.md
# Rename Unit with Result Integration

This block renames registers for two instruction streams that share one physical register file: a main thread and a single helper thread that runs a short slice of the program ahead of it. Each stream has its own logical-to-physical map, and a single pool of free physical registers serves both. A fork copies the main map into the helper map, so the helper starts from the values the main thread already has. All exchange between the two streams goes through physical register names.

Every instruction the helper renames leaves a record in a small integration table: its PC, its two renamed source tags and the physical register it was given. When the main thread renames an instruction whose PC and renamed sources equal a live record, it takes over that record's physical register instead of allocating one. The instruction is flagged as integrated, so the backend does not execute it again. Registers the helper allocated and the main thread never took go back to the pool when their record is overwritten or when the helper is squashed. The backend returns dead registers through a one-tag release port.

Top module: `rename_integrate`

## Requirements
- R1: After reset, both maps send logical register i to physical register i. Physical registers 32 to 127 are free and 0 to 31 are not.
- R2: A main rename that does not integrate reads its sources through the main map and takes the lowest-numbered free register. `m_old_pdst` reports the mapping it replaces, and the main map holds the new tag from the next cycle on.
- R3: A helper rename reads its sources through the helper map and takes the highest-numbered free register. It writes a table record {PC, source tags, destination} and updates the helper map.
- R4: When `fork_i` is high, the helper map is loaded with the main map, including any main rename granted in that same cycle. A helper rename in that cycle is stalled.
- R5: A main rename whose PC and renamed source tags equal a valid record is granted with that record's destination, with `m_integrated` high, and takes no register from the free list. When several records match, the one with the lowest slot index is used.
- R6: A record that has been claimed is invalidated, so the same main instruction renamed again does not integrate.
- R7: The table has 32 slots and is written in FIFO (ring) order. Overwriting a valid, unclaimed record returns its destination register to the free list.
- R8: When `squash_i` is high, the destinations of all valid records return to the free list and the table empties. In that cycle, helper renames are stalled and main lookups do not integrate.
- R9: With no free register, neither thread is granted a rename that needs allocation. A main rename that integrates is still granted.
- R10: When exactly one register is free and both threads need one, the main thread gets it and the helper is stalled.
- R11: A tag presented with `rel_valid` becomes free from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fork_i | input | 1 | Start helper: copy main map into helper map |
| squash_i | input | 1 | Kill helper: release its unclaimed registers |
| m_valid | input | 1 | Main thread has an instruction to rename |
| m_pc | input | 32 | Main instruction PC |
| m_src1 | input | 5 | Main logical source 1 |
| m_src2 | input | 5 | Main logical source 2 |
| m_dst | input | 5 | Main logical destination |
| m_grant | output | 1 | Main rename accepted this cycle |
| m_psrc1 | output | 7 | Main physical source 1 |
| m_psrc2 | output | 7 | Main physical source 2 |
| m_pdst | output | 7 | Main physical destination |
| m_old_pdst | output | 7 | Previous mapping of `m_dst` |
| m_integrated | output | 1 | Result taken from helper; skip execution |
| h_valid | input | 1 | Helper has an instruction to rename |
| h_pc | input | 32 | Helper instruction PC |
| h_src1 | input | 5 | Helper logical source 1 |
| h_src2 | input | 5 | Helper logical source 2 |
| h_dst | input | 5 | Helper logical destination |
| h_grant | output | 1 | Helper rename accepted this cycle |
| h_psrc1 | output | 7 | Helper physical source 1 |
| h_psrc2 | output | 7 | Helper physical source 2 |
| h_pdst | output | 7 | Helper physical destination |
| rel_valid | input | 1 | Release a physical register |
| rel_tag | input | 7 | Register being released |

## Verification
A corrupted free bit shows up on the next allocating rename as a wrong `m_pdst` or `h_pdst`, because the lowest and highest picks expose the free set from both ends. A stale or missing table record shows up on the first main rename with a matching PC as a wrong `m_integrated` or destination. A wrong map entry appears one cycle after the update, as a wrong source tag on the next rename that reads it. The bench keeps its own free set, maps and table, and compares every output on every cycle, so a divergence is caught in the cycle it first reaches a port.

// File: rtl/ri_pkg.sv
package ri_pkg;
  parameter int LOG_N  = 32;
  parameter int PHYS_N = 128;
  parameter int ITAB_N = 32;
  parameter int PC_W   = 32;

  localparam int LG_W = $clog2(LOG_N);
  localparam int PT_W = $clog2(PHYS_N);
  localparam int IX_W = $clog2(ITAB_N);

  typedef logic [PT_W-1:0] ptag_t;

  typedef struct packed {
    logic [PC_W-1:0] pc;
    ptag_t           s1;
    ptag_t           s2;
    ptag_t           d;
  } ient_t;

  // lowest set bit of a free vector (0 when empty)
  function automatic ptag_t low_pick(input logic [PHYS_N-1:0] v);
    low_pick = '0;
    for (int i = PHYS_N - 1; i >= 0; i--)
      if (v[i]) low_pick = ptag_t'(i);
  endfunction

  // highest set bit of a free vector (0 when empty)
  function automatic ptag_t high_pick(input logic [PHYS_N-1:0] v);
    high_pick = '0;
    for (int i = 0; i < PHYS_N; i++)
      if (v[i]) high_pick = ptag_t'(i);
  endfunction
endpackage

// File: rtl/rn_freelist.sv
module rn_freelist import ri_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              m_req,
  input  logic              h_req,
  input  logic [PHYS_N-1:0] ret_mask,
  output logic              m_ok,
  output ptag_t             m_tag,
  output logic              h_ok,
  output ptag_t             h_tag
);
  logic [PHYS_N-1:0] fl;
  logic [PHYS_N-1:0] take;
  logic              any_free;

  assign any_free = |fl;
  assign m_tag    = low_pick(fl);
  assign h_tag    = high_pick(fl);
  assign m_ok     = any_free;
  // one register left and both asking: main wins
  assign h_ok     = any_free && !(m_req && (m_tag == h_tag));

  always_comb begin
    take = '0;
    if (m_req && m_ok) take[m_tag] = 1'b1;
    if (h_req && h_ok) take[h_tag] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) fl <= {{(PHYS_N-LOG_N){1'b1}}, {LOG_N{1'b0}}};
    else        fl <= (fl & ~take) | ret_mask;
  end

  // R11: a register coming back must not already be free
  a_r11_release_not_free: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_mask & fl) == '0);

  // R10: the two threads never receive the same register
  a_r10_distinct_tags: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && m_ok && h_req && h_ok) |-> (m_tag != h_tag));
endmodule

// File: rtl/rn_itab.sv
module rn_itab import ri_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              squash,
  input  logic              wr_en,
  input  ient_t             wr_ent,
  input  logic              lk_en,
  input  logic [PC_W-1:0]   lk_pc,
  input  ptag_t             lk_s1,
  input  ptag_t             lk_s2,
  output logic              hit,
  output ptag_t             hit_dst,
  output logic [PHYS_N-1:0] rel_mask
);
  ient_t             ent [ITAB_N];
  logic [ITAB_N-1:0] vld;
  logic [ITAB_N-1:0] match;
  logic [IX_W-1:0]   wp;
  logic [IX_W-1:0]   hit_ix;
  logic              evict;

  for (genvar g = 0; g < ITAB_N; g++) begin : g_cmp
    assign match[g] = vld[g] && (ent[g].pc == lk_pc) &&
                      (ent[g].s1 == lk_s1) && (ent[g].s2 == lk_s2);
  end

  always_comb begin
    hit_ix = '0;
    for (int i = ITAB_N - 1; i >= 0; i--)
      if (match[i]) hit_ix = IX_W'(i);
  end

  assign hit     = lk_en && (|match);
  assign hit_dst = ent[hit_ix].d;
  assign evict   = wr_en && vld[wp] && !(hit && (hit_ix == wp));

  always_comb begin
    rel_mask = '0;
    if (evict) rel_mask[ent[wp].d] = 1'b1;
    if (squash)
      for (int i = 0; i < ITAB_N; i++)
        if (vld[i]) rel_mask[ent[i].d] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      wp  <= '0;
    end else if (squash) begin
      vld <= '0;
    end else begin
      if (hit)   vld[hit_ix] <= 1'b0;
      if (wr_en) begin
        vld[wp] <= 1'b1;
        wp      <= wp + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !squash) ent[wp] <= wr_ent;
  end

  // R7: a register being claimed is never handed back in the same cycle
  a_r7_claim_not_released: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> !rel_mask[hit_dst]);
endmodule

// File: rtl/rename_integrate.sv
module rename_integrate import ri_pkg::*; (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fork_i,
  input  logic            squash_i,
  input  logic            m_valid,
  input  logic [PC_W-1:0] m_pc,
  input  logic [LG_W-1:0] m_src1,
  input  logic [LG_W-1:0] m_src2,
  input  logic [LG_W-1:0] m_dst,
  output logic            m_grant,
  output logic [PT_W-1:0] m_psrc1,
  output logic [PT_W-1:0] m_psrc2,
  output logic [PT_W-1:0] m_pdst,
  output logic [PT_W-1:0] m_old_pdst,
  output logic            m_integrated,
  input  logic            h_valid,
  input  logic [PC_W-1:0] h_pc,
  input  logic [LG_W-1:0] h_src1,
  input  logic [LG_W-1:0] h_src2,
  input  logic [LG_W-1:0] h_dst,
  output logic            h_grant,
  output logic [PT_W-1:0] h_psrc1,
  output logic [PT_W-1:0] h_psrc2,
  output logic [PT_W-1:0] h_pdst,
  input  logic            rel_valid,
  input  logic [PT_W-1:0] rel_tag
);
  ptag_t mmap    [LOG_N];
  ptag_t hmap    [LOG_N];
  ptag_t mmap_nx [LOG_N];

  // named internal events
  logic              m_hit, m_alloc, h_act;
  logic              fl_m_ok, fl_h_ok;
  ptag_t             fl_m_tag, fl_h_tag, hit_dst;
  logic [PHYS_N-1:0] tab_rel, port_rel;
  ient_t             wr_ent;

  assign m_psrc1    = mmap[m_src1];
  assign m_psrc2    = mmap[m_src2];
  assign m_old_pdst = mmap[m_dst];
  assign h_psrc1    = hmap[h_src1];
  assign h_psrc2    = hmap[h_src2];

  assign m_alloc = m_valid && !m_hit;
  assign h_act   = h_valid && !fork_i && !squash_i;

  assign m_grant      = m_valid && (m_hit || fl_m_ok);
  assign m_pdst       = m_hit ? hit_dst : fl_m_tag;
  assign m_integrated = m_valid && m_hit;
  assign h_grant      = h_act && fl_h_ok;
  assign h_pdst       = fl_h_tag;

  assign wr_ent = '{pc: h_pc, s1: h_psrc1, s2: h_psrc2, d: h_pdst};

  always_comb begin
    port_rel = '0;
    if (rel_valid) port_rel[rel_tag] = 1'b1;
  end

  rn_itab u_itab (
    .clk      (clk),
    .rst_n    (rst_n),
    .squash   (squash_i),
    .wr_en    (h_grant),
    .wr_ent   (wr_ent),
    .lk_en    (m_valid && !squash_i),
    .lk_pc    (m_pc),
    .lk_s1    (m_psrc1),
    .lk_s2    (m_psrc2),
    .hit      (m_hit),
    .hit_dst  (hit_dst),
    .rel_mask (tab_rel)
  );

  rn_freelist u_fl (
    .clk      (clk),
    .rst_n    (rst_n),
    .m_req    (m_alloc),
    .h_req    (h_act),
    .ret_mask (tab_rel | port_rel),
    .m_ok     (fl_m_ok),
    .m_tag    (fl_m_tag),
    .h_ok     (fl_h_ok),
    .h_tag    (fl_h_tag)
  );

  always_comb begin
    for (int i = 0; i < LOG_N; i++) mmap_nx[i] = mmap[i];
    if (m_grant) mmap_nx[m_dst] = m_pdst;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LOG_N; i++) begin
        mmap[i] <= ptag_t'(i);
        hmap[i] <= ptag_t'(i);
      end
    end else begin
      for (int i = 0; i < LOG_N; i++) mmap[i] <= mmap_nx[i];
      if (fork_i) begin
        for (int i = 0; i < LOG_N; i++) hmap[i] <= mmap_nx[i];
      end else if (h_grant) begin
        hmap[h_dst] <= h_pdst;
      end
    end
  end

  // R4: a fork cycle never grants a helper rename
  a_r4_fork_stalls_helper: assert property (@(posedge clk) disable iff (!rst_n)
    fork_i |-> !h_grant);

  // R5: after integration the main map points at the claimed register
  a_r5_map_takes_claim: assert property (@(posedge clk) disable iff (!rst_n)
    m_integrated |=> (mmap[$past(m_dst)] == $past(hit_dst)));

  // R8: no integration while the helper is being squashed
  a_r8_squash_no_integrate: assert property (@(posedge clk) disable iff (!rst_n)
    squash_i |-> !m_integrated);

  // R2: a freshly allocated register differs from the mapping it replaces
  a_r2_fresh_dst_differs: assert property (@(posedge clk) disable iff (!rst_n)
    (m_grant && !m_integrated) |-> (m_pdst != m_old_pdst));
endmodule

// File: tb/tb_rename_integrate.sv
module tb_rename_integrate;
  import ri_pkg::*;
  timeunit 1ns;
  timeprecision 1ps;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst_n, fork_i, squash_i;
  logic            m_valid, h_valid, rel_valid;
  logic [PC_W-1:0] m_pc, h_pc;
  logic [LG_W-1:0] m_src1, m_src2, m_dst, h_src1, h_src2, h_dst;
  logic [PT_W-1:0] rel_tag;
  logic            m_grant, m_integrated, h_grant;
  logic [PT_W-1:0] m_psrc1, m_psrc2, m_pdst, m_old_pdst;
  logic [PT_W-1:0] h_psrc1, h_psrc2, h_pdst;

  rename_integrate dut (.*);

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // behavioural reference state
  int              mm [LOG_N];
  int              hm [LOG_N];
  bit              fr [PHYS_N];
  bit              tv [ITAB_N];
  logic [PC_W-1:0] tpc [ITAB_N];
  int              ts1 [ITAB_N];
  int              ts2 [ITAB_N];
  int              td [ITAB_N];
  int              wp;
  int              dead [$];

  task automatic cmp(string tag, string what, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic idle();
    fork_i = 0; squash_i = 0; m_valid = 0; h_valid = 0; rel_valid = 0;
    m_pc = '0; m_src1 = '0; m_src2 = '0; m_dst = '0;
    h_pc = '0; h_src1 = '0; h_src2 = '0; h_dst = '0; rel_tag = '0;
  endtask

  // one clock: compare every output with the reference, then advance it
  task automatic step(string tag);
    int p1, p2, hp1, hp2, hix, lo, hi, mpd, old;
    bit hit, mg, hg, mreq, hact;
    #1;
    p1 = mm[m_src1]; p2 = mm[m_src2];
    hit = 0; hix = 0;
    if (m_valid && !squash_i)
      for (int i = ITAB_N - 1; i >= 0; i--)
        if (tv[i] && tpc[i] == m_pc && ts1[i] == p1 && ts2[i] == p2) begin
          hit = 1; hix = i;
        end
    lo = -1; hi = -1;
    for (int i = 0; i < PHYS_N; i++)
      if (fr[i]) begin
        if (lo < 0) lo = i;
        hi = i;
      end
    mreq = m_valid && !hit;
    mg   = m_valid && (hit || lo >= 0);
    mpd  = hit ? td[hix] : lo;
    old  = mm[m_dst];
    hact = h_valid && !fork_i && !squash_i;
    hg   = hact && hi >= 0 && !(mreq && hi == lo);
    hp1  = hm[h_src1]; hp2 = hm[h_src2];

    cmp(tag, "m_grant", int'(m_grant), int'(mg));
    cmp(tag, "h_grant", int'(h_grant), int'(hg));
    if (m_valid) begin
      cmp(tag, "m_psrc1", int'(m_psrc1), p1);
      cmp(tag, "m_psrc2", int'(m_psrc2), p2);
      cmp(tag, "m_integrated", int'(m_integrated), int'(hit));
    end
    if (mg) begin
      cmp(tag, "m_pdst", int'(m_pdst), mpd);
      cmp(tag, "m_old_pdst", int'(m_old_pdst), old);
    end
    if (h_valid) begin
      cmp(tag, "h_psrc1", int'(h_psrc1), hp1);
      cmp(tag, "h_psrc2", int'(h_psrc2), hp2);
    end
    if (hg) cmp(tag, "h_pdst", int'(h_pdst), hi);

    @(posedge clk);
    if (mg) begin
      if (!hit) fr[lo] = 0;
      else      tv[hix] = 0;
      mm[m_dst] = mpd;
      dead.push_back(old);
    end
    if (hg) begin
      fr[hi] = 0;
      if (tv[wp]) fr[td[wp]] = 1;
      tv[wp] = 1; tpc[wp] = h_pc; ts1[wp] = hp1; ts2[wp] = hp2; td[wp] = hi;
      wp = (wp + 1) % ITAB_N;
      hm[h_dst] = hi;
    end
    if (squash_i)
      for (int i = 0; i < ITAB_N; i++)
        if (tv[i]) begin fr[td[i]] = 1; tv[i] = 0; end
    if (rel_valid) fr[rel_tag] = 1;
    if (fork_i)
      for (int i = 0; i < LOG_N; i++) hm[i] = mm[i];
    @(negedge clk);
  endtask

  initial begin
    #1ms;
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int x;
    idle();
    rst_n = 0;
    for (int i = 0; i < LOG_N; i++) begin mm[i] = i; hm[i] = i; end
    for (int i = 0; i < PHYS_N; i++) fr[i] = (i >= LOG_N);
    for (int i = 0; i < ITAB_N; i++) tv[i] = 0;
    wp = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R1: identity maps and free range after reset
    m_valid = 1; m_pc = 0; m_src1 = 5; m_src2 = 6; m_dst = 7;
    h_valid = 1; h_pc = 'h999; h_src1 = 1; h_src2 = 2; h_dst = 3;
    #1;
    cmp("R1", "m_psrc1", int'(m_psrc1), 5);
    cmp("R1", "h_psrc2", int'(h_psrc2), 2);
    cmp("R2", "m_pdst lowest free", int'(m_pdst), 32);
    cmp("R3", "h_pdst highest free", int'(h_pdst), 127);
    step("R1");

    // R7: fill all slots, the wrap evicts the first record's register
    idle();
    for (int k = 0; k < ITAB_N; k++) begin
      h_valid = 1; h_pc = PC_W'(1000 + k); h_dst = LG_W'(k % 8);
      step("R7");
    end
    h_valid = 1; h_pc = 2000; h_dst = 4;
    #1 cmp("R7", "evicted reg reused", int'(h_pdst), 127);
    step("R7");

    // R8: squash empties the table, blocks helper and integration
    idle();
    squash_i = 1; h_valid = 1; h_pc = 3000;
    m_valid = 1; m_pc = 1002; m_src1 = 0; m_src2 = 0; m_dst = 9;
    #1;
    cmp("R8", "m_integrated", int'(m_integrated), 0);
    cmp("R8", "h_grant", int'(h_grant), 0);
    step("R8");
    idle();
    m_valid = 1; m_pc = 1003; m_src1 = 0; m_src2 = 0; m_dst = 9;
    #1 cmp("R8", "table empty", int'(m_integrated), 0);
    step("R8");

    // R4: fork copies the main map including this cycle's rename
    idle();
    fork_i = 1; m_valid = 1; m_pc = 50; m_src1 = 1; m_src2 = 2; m_dst = 9;
    h_valid = 1;
    #1 cmp("R4", "h_grant on fork", int'(h_grant), 0);
    step("R4");
    idle();
    h_valid = 1; h_pc = 60; h_src1 = 9; h_src2 = 7; h_dst = 10;
    #1 cmp("R4", "h_psrc1 from copied map", int'(h_psrc1), mm[9]);
    step("R4");

    // R5: main integrates the helper result
    idle();
    m_valid = 1; m_pc = 60; m_src1 = 9; m_src2 = 7; m_dst = 10;
    #1 cmp("R5", "m_integrated", int'(m_integrated), 1);
    step("R5");
    // R6: claimed record cannot be claimed again
    #1 cmp("R6", "m_integrated second time", int'(m_integrated), 0);
    step("R6");

    // helper record kept for the empty-list case
    idle();
    h_valid = 1; h_pc = 80; h_src1 = 11; h_src2 = 12; h_dst = 13;
    step("R3");

    // R9: drain the free list with main renames
    idle();
    m_valid = 1; m_pc = 70; m_src1 = 20; m_src2 = 21; m_dst = 22;
    for (int k = 0; k < 140; k++) step("R9");
    #1 cmp("R9", "main stalls when empty", int'(m_grant), 0);
    h_valid = 1; h_pc = 90; h_dst = 14;
    #1 cmp("R9", "helper stalls when empty", int'(h_grant), 0);
    step("R9");
    m_pc = 80; m_src1 = 11; m_src2 = 12; m_dst = 13; h_valid = 0;
    #1;
    cmp("R9", "integrating main proceeds", int'(m_grant), 1);
    cmp("R9", "integrated flag", int'(m_integrated), 1);
    step("R9");

    // R11: released register becomes the next allocation
    idle();
    rel_valid = 1; x = dead.pop_front(); rel_tag = PT_W'(x);
    step("R11");
    // R10: single free register, main wins
    idle();
    m_valid = 1; m_pc = 70; m_src1 = 20; m_src2 = 21; m_dst = 22;
    h_valid = 1; h_pc = 91; h_dst = 15;
    #1;
    cmp("R11", "m_pdst is released reg", int'(m_pdst), x);
    cmp("R10", "h_grant under contention", int'(h_grant), 0);
    step("R10");

    // mixed traffic compared cycle by cycle
    for (int c = 0; c < 4000; c++) begin
      fork_i    = ($urandom % 20) == 0;
      squash_i  = ($urandom % 30) == 0;
      m_valid   = ($urandom % 10) < 7;
      m_pc      = PC_W'($urandom % 4);
      m_src1    = LG_W'($urandom % 4);
      m_src2    = LG_W'($urandom % 4);
      m_dst     = LG_W'($urandom % 4);
      h_valid   = ($urandom % 10) < 6;
      h_pc      = PC_W'($urandom % 4);
      h_src1    = LG_W'($urandom % 4);
      h_src2    = LG_W'($urandom % 4);
      h_dst     = LG_W'($urandom % 4);
      rel_valid = 0;
      if (dead.size() > 0 && ($urandom % 3) != 0) begin
        rel_valid = 1;
        x = dead.pop_front();
        rel_tag = PT_W'(x);
      end
      step("R2");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule